// File: doc/BRIEF.md
# RTC Prescaler and Periodic Interrupt Controller

This block turns a slow reference clock, delivered as a one-cycle enable on the system clock, into the timing events of a real-time clock. A reference of 32768 Hz, 32000 Hz or 38400 Hz is chosen by a control field. It is divided first into a 512 Hz base rate. A fractional accumulator keeps the average exact when the reference is not a multiple of 512. A binary chain then splits the base rate into 256, 128, 64, 32, 16, 8, 4, 2 and 1 Hz. The 1 Hz event drives a tick output to the time counters, which lie outside this block.

Every rate event, and the alarm and stopwatch events that arrive from outside, sets its own bit in a status register. Software clears a bit by writing 1 to it. A mask register selects which status bits drive the single interrupt line. Status bits set whether or not they are masked, so software can poll any event. The block has one 16-bit register port with a 2-bit word address and a combinational read path.

Top module: `rtc_pic`

## Requirements
- R1: Control word (address 0) bits 6:5 select the reference: 00 = 32768 Hz, 01 = 32000 Hz, 10 = 38400 Hz. The 1 Hz status bit (bit 4) sets on exactly the 32768th, 32000th or 38400th reference tick after the last control write, and not one tick earlier.
- R2: Status bits 15 down to 8 are the 512, 256, 128, 64, 32, 16, 8 and 4 Hz events, and bit 7 is 2 Hz. The 512 Hz event fires every 64 reference ticks at 32768 Hz and every 75 at 38400 Hz. At 32000 Hz its periods alternate 62 then 63 ticks, starting from the last control write. The 2 Hz event fires on the 256th base event.
- R3: Writing the status register (address 1) clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R4: When an event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: The alarm input sets status bit 2 and the stopwatch input sets status bit 0, whatever the mask holds.
- R6: The interrupt output is high exactly while some status bit and the same bit of the mask register (address 2) are both 1.
- R7: The tick output pulses for one cycle, the cycle after the 1 Hz event, and only while control bit 7 is 1.
- R8: Selection code 11 stops the prescaler: no rate event and no tick occur however many reference ticks arrive.
- R9: A control write restarts the prescaler from zero. Cycles without a reference tick do not advance it.
- R10: After reset, every register reads 0. Status and mask bits 1, 3, 5 and 6 are not implemented and read 0. A read of address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | One-cycle enable per reference clock period |
| alarm_evt | input | 1 | Alarm match event pulse |
| stopwatch_evt | input | 1 | Stopwatch expiry event pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address: 0 control, 1 status, 2 mask |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| sec_tick | output | 1 | 1 Hz tick to the time counters |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that a raised event always leaves its status bit set, even against a simultaneous clear. They also check that a status bit only falls when a write cleared it, and that a tick only follows a 1 Hz event taken while enabled. Further checks are that the reserved selection never produces a base event and that the interrupt only rises after an event or a mask write. The exact tick counts at which each rate fires for each reference can only be shown by the bench's scenarios. The same holds for the alternating 62/63 period at 32000 Hz, the gating of the tick by the enable bit, and the read-back of masked pending bits.

// File: rtl/rtc_pic_pkg.sv
package rtc_pic_pkg;

  localparam int REG_W     = 16;
  localparam int RATE_BITS = 9;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_MASK = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  localparam logic [1:0] SEL_OFF = 2'b11;

  localparam int BIT_SW   = 0;
  localparam int BIT_ALM  = 2;
  localparam int BIT_HZ1  = 4;
  localparam int BIT_HZ2  = 7;
  localparam int BIT_SMP0 = 8;

  localparam int CTRL_SEL_LO = 5;
  localparam int CTRL_EN     = 7;

  // Bits of the status and mask registers that exist
  function automatic logic [REG_W-1:0] impl_bits();
    logic [REG_W-1:0] m;
    m = '0;
    m[BIT_SW]  = 1'b1;
    m[BIT_ALM] = 1'b1;
    m[BIT_HZ1] = 1'b1;
    m[BIT_HZ2] = 1'b1;
    for (int i = BIT_SMP0; i < REG_W; i++) m[i] = 1'b1;
    return m;
  endfunction

  // Whole reference ticks per base period
  function automatic int unsigned base_quot(int unsigned hz, int unsigned bits);
    return hz >> bits;
  endfunction

  // Fractional remainder added to the accumulator each base period
  function automatic int unsigned base_rem(int unsigned hz, int unsigned bits);
    return hz % (32'd1 << bits);
  endfunction

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

endpackage

// File: rtl/rtc_ref_div.sv
module rtc_ref_div
  import rtc_pic_pkg::*;
#(
  parameter int unsigned RBITS   = RATE_BITS,
  parameter int unsigned REF0_HZ = 32768,
  parameter int unsigned REF1_HZ = 32000,
  parameter int unsigned REF2_HZ = 38400
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       ref_tick,
  input  logic [1:0] sel,
  output logic       base_tick
);

  localparam int unsigned Q0   = base_quot(REF0_HZ, RBITS);
  localparam int unsigned Q1   = base_quot(REF1_HZ, RBITS);
  localparam int unsigned Q2   = base_quot(REF2_HZ, RBITS);
  localparam int unsigned R0   = base_rem(REF0_HZ, RBITS);
  localparam int unsigned R1   = base_rem(REF1_HZ, RBITS);
  localparam int unsigned R2   = base_rem(REF2_HZ, RBITS);
  localparam int unsigned QMAX = max3(Q0, Q1, Q2);
  localparam int          CW   = $clog2(QMAX + 2);

  logic [CW-1:0]    cnt_q;
  logic [RBITS-1:0] acc_q;
  logic [CW-1:0]    quot;
  logic [RBITS-1:0] rem;
  logic             run;
  logic [RBITS:0]   acc_sum;
  logic             carry;
  logic [CW-1:0]    last;

  always_comb begin
    run  = 1'b1;
    quot = CW'(Q0);
    rem  = RBITS'(R0);
    unique case (sel)
      2'b00: begin quot = CW'(Q0); rem = RBITS'(R0); end
      2'b01: begin quot = CW'(Q1); rem = RBITS'(R1); end
      2'b10: begin quot = CW'(Q2); rem = RBITS'(R2); end
      default: run = 1'b0;
    endcase
  end

  assign acc_sum   = {1'b0, acc_q} + {1'b0, rem};
  assign carry     = acc_sum[RBITS];
  assign last      = quot + CW'(carry) - CW'(1);
  assign base_tick = run && ref_tick && !restart && (cnt_q == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (run && ref_tick) begin
      if (base_tick) begin
        cnt_q <= '0;
        acc_q <= acc_sum[RBITS-1:0];
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

endmodule

// File: rtl/rtc_rate_chain.sv
module rtc_rate_chain
  import rtc_pic_pkg::*;
#(
  parameter int RBITS = RATE_BITS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         base_tick,
  output logic [RBITS:0] rate_evt
);

  logic [RBITS-1:0] ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ph_q <= '0;
    else if (restart)   ph_q <= '0;
    else if (base_tick) ph_q <= ph_q + RBITS'(1);
  end

  // rate_evt[k] is the 2^k Hz event: it fires when the low RBITS-k phase
  // bits are all ones on a base event
  for (genvar k = 0; k <= RBITS; k++) begin : g_rate
    localparam int LOW = RBITS - k;
    localparam logic [RBITS-1:0] LMASK = RBITS'((64'd1 << LOW) - 64'd1);
    assign rate_evt[k] = base_tick && ((ph_q & LMASK) == LMASK);
  end

endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtc_pic_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_vec,
  input  logic [W-1:0] clr_vec,
  input  logic         mask_we,
  input  logic [W-1:0] mask_wdata,
  output logic [W-1:0] status_q,
  output logic [W-1:0] mask_q,
  output logic         irq
);

  localparam logic [W-1:0] IMPL = W'(impl_bits());

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '0;
    end else begin
      status_q <= (status_q & ~clr_vec) | (evt_vec & IMPL);
      if (mask_we) mask_q <= mask_wdata & IMPL;
    end
  end

  assign irq = |(status_q & mask_q);

endmodule

// File: rtl/rtc_pic.sv
module rtc_pic
  import rtc_pic_pkg::*;
#(
  parameter int unsigned REF0_HZ = 32768,
  parameter int unsigned REF1_HZ = 32000,
  parameter int unsigned REF2_HZ = 38400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              alarm_evt,
  input  logic              stopwatch_evt,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              sec_tick,
  output logic              irq
);

  logic             en_q;
  logic [1:0]       sel_q;
  logic             ctrl_we;
  logic             mask_we;
  logic             base_tick;
  logic [RATE_BITS:0] rate_evt;
  logic             hz1_evt;
  logic [REG_W-1:0] evt_vec;
  logic [REG_W-1:0] clr_vec;
  logic [REG_W-1:0] status_q;
  logic [REG_W-1:0] mask_q;

  assign ctrl_we = reg_we && (reg_addr == REG_CTRL);
  assign mask_we = reg_we && (reg_addr == REG_MASK);
  assign clr_vec = (reg_we && (reg_addr == REG_STAT)) ? reg_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      sel_q <= 2'b00;
    end else if (ctrl_we) begin
      en_q  <= reg_wdata[CTRL_EN];
      sel_q <= reg_wdata[CTRL_SEL_LO+1:CTRL_SEL_LO];
    end
  end

  rtc_ref_div #(
    .RBITS  (RATE_BITS),
    .REF0_HZ(REF0_HZ),
    .REF1_HZ(REF1_HZ),
    .REF2_HZ(REF2_HZ)
  ) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (ctrl_we),
    .ref_tick (ref_tick),
    .sel      (sel_q),
    .base_tick(base_tick)
  );

  rtc_rate_chain #(.RBITS(RATE_BITS)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (ctrl_we),
    .base_tick(base_tick),
    .rate_evt (rate_evt)
  );

  assign hz1_evt = rate_evt[0];

  always_comb begin
    evt_vec          = '0;
    evt_vec[BIT_SW]  = stopwatch_evt;
    evt_vec[BIT_ALM] = alarm_evt;
    evt_vec[BIT_HZ1] = rate_evt[0];
    evt_vec[BIT_HZ2] = rate_evt[1];
    for (int j = 0; j <= RATE_BITS - 2; j++) evt_vec[BIT_SMP0 + j] = rate_evt[2 + j];
  end

  rtc_irq_ctrl #(.W(REG_W)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_vec   (evt_vec),
    .clr_vec   (clr_vec),
    .mask_we   (mask_we),
    .mask_wdata(reg_wdata),
    .status_q  (status_q),
    .mask_q    (mask_q),
    .irq       (irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sec_tick <= 1'b0;
    else        sec_tick <= en_q && hz1_evt;
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      REG_CTRL: begin
        reg_rdata[CTRL_EN] = en_q;
        reg_rdata[CTRL_SEL_LO+1:CTRL_SEL_LO] = sel_q;
      end
      REG_STAT: reg_rdata = status_q;
      REG_MASK: reg_rdata = mask_q;
      default:  reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/rtc_pic_chk.sv
module rtc_pic_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sec_tick,
  input logic        irq,
  input logic        en,
  input logic [1:0]  sel,
  input logic        base_tick,
  input logic        hz1_evt,
  input logic        mask_we,
  input logic [15:0] evt_vec,
  input logic [15:0] clr_vec,
  input logic [15:0] status_q
);

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_vec) |=> ((status_q & $past(evt_vec)) == $past(evt_vec)));

  // R3
  w1c_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~status_q & $past(status_q) & ~$past(clr_vec)) == 16'h0000));

  // R7
  tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |-> $past(hz1_evt && en));

  // R8
  reserved_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b11) |-> !base_tick);

  // R6
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(mask_we || (|evt_vec)));

  // R1
  one_hz_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hz1_evt |-> base_tick);

endmodule

bind rtc_pic rtc_pic_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sec_tick (sec_tick),
  .irq      (irq),
  .en       (en_q),
  .sel      (sel_q),
  .base_tick(base_tick),
  .hz1_evt  (hz1_evt),
  .mask_we  (mask_we),
  .evt_vec  (evt_vec),
  .clr_vec  (clr_vec),
  .status_q (status_q)
);

// File: tb/test_rtc_pic.sv
module test_rtc_pic;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic        alarm_evt = 1'b0;
  logic        stopwatch_evt = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic        sec_tick;
  logic        irq;

  int checks = 0;
  int failures = 0;
  int sec_cnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rtc_pic i_rtc_pic (
    .clk          (clk),
    .rst_n        (rst_n),
    .ref_tick     (ref_tick),
    .alarm_evt    (alarm_evt),
    .stopwatch_evt(stopwatch_evt),
    .reg_we       (reg_we),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .sec_tick     (sec_tick),
    .irq          (irq)
  );

  always @(negedge clk) if (sec_tick) sec_cnt++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = 16'h0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic run(input int n);
    if (n > 0) begin
      ref_tick = 1'b1;
      repeat (n) @(negedge clk);
      ref_tick = 1'b0;
    end
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic stat_bit(input int b, input bit exp, input string req);
    logic [15:0] v;
    rd(2'd1, v);
    check(v[b] == exp, req, int'(v[b]), int'(exp));
  endtask

  task automatic t_reset();
    logic [15:0] v;
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      check(v == 16'h0, "R10 reset read", int'(v), 0);
    end
    check(irq == 1'b0 && sec_tick == 1'b0, "R10 reset outputs", int'({irq, sec_tick}), 0);
  endtask

  task automatic t_ref_a();
    int s0;
    wr(2'd0, 16'h0080);
    wr(2'd1, 16'hFFFF);
    s0 = sec_cnt;
    run(63);  stat_bit(15, 1'b0, "R2 512Hz early");
    run(1);   stat_bit(15, 1'b1, "R2 512Hz at 64");
    stat_bit(14, 1'b0, "R2 256Hz not yet");
    run(64);  stat_bit(14, 1'b1, "R2 256Hz at 128");
    stat_bit(13, 1'b0, "R2 128Hz not yet");
    run(32768 - 128 - 1); stat_bit(4, 1'b0, "R1 1Hz early at 32768 ref");
    run(1);   stat_bit(4, 1'b1, "R1 1Hz at 32768");
    stat_bit(8, 1'b1, "R2 4Hz with 1Hz");
    idle();
    check(sec_cnt - s0 == 1, "R7 tick once when enabled", sec_cnt - s0, 1);
  endtask

  task automatic t_ref_b();
    int s0;
    wr(2'd0, 16'h00A0);
    wr(2'd1, 16'hFFFF);
    s0 = sec_cnt;
    run(61);  stat_bit(15, 1'b0, "R2 32000 first period early");
    run(1);   stat_bit(15, 1'b1, "R2 32000 first period 62");
    wr(2'd1, 16'h8000);
    stat_bit(15, 1'b0, "R3 clear 512Hz bit");
    run(62);  stat_bit(15, 1'b0, "R2 32000 second period early");
    run(1);   stat_bit(15, 1'b1, "R2 32000 second period 63");
    run(16000 - 125 - 1); stat_bit(7, 1'b0, "R2 2Hz early");
    run(1);   stat_bit(7, 1'b1, "R2 2Hz at 16000");
    run(15999); stat_bit(4, 1'b0, "R1 1Hz early at 32000 ref");
    run(1);   stat_bit(4, 1'b1, "R1 1Hz at 32000");
    idle();
    check(sec_cnt - s0 == 1, "R7 tick 32000", sec_cnt - s0, 1);
  endtask

  task automatic t_ref_c();
    wr(2'd0, 16'h00C0);
    wr(2'd1, 16'hFFFF);
    run(74);  stat_bit(15, 1'b0, "R2 38400 early");
    run(1);   stat_bit(15, 1'b1, "R2 38400 at 75");
    run(38399 - 75); stat_bit(4, 1'b0, "R1 1Hz early at 38400 ref");
    run(1);   stat_bit(4, 1'b1, "R1 1Hz at 38400");
  endtask

  task automatic t_w1c_and_irq();
    logic [15:0] v;
    wr(2'd1, 16'hFFFF);
    wr(2'd2, 16'h0000);
    alarm_evt = 1'b1; stopwatch_evt = 1'b1;
    idle();
    alarm_evt = 1'b0; stopwatch_evt = 1'b0;
    rd(2'd1, v);
    check(v == 16'h0005, "R5 alarm and stopwatch set while masked", int'(v), 16'h0005);
    check(irq == 1'b0, "R6 irq low with zero mask", int'(irq), 0);
    wr(2'd1, 16'h0001);
    rd(2'd1, v);
    check(v == 16'h0004, "R3 zero bits unchanged", int'(v), 16'h0004);
    wr(2'd2, 16'hFFFF);
    rd(2'd2, v);
    check(v == 16'hFF95, "R10 unimplemented mask bits", int'(v), 16'hFF95);
    check(irq == 1'b1, "R6 irq high on enabled pending", int'(irq), 1);
    // simultaneous event and clear on bit 2
    reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = 16'h0004; alarm_evt = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = 16'h0; alarm_evt = 1'b0;
    stat_bit(2, 1'b1, "R4 set wins over clear");
    wr(2'd1, 16'h0004);
    stat_bit(2, 1'b0, "R3 alarm cleared");
    check(irq == 1'b0, "R6 irq low after clear", int'(irq), 0);
    wr(2'd2, 16'h0000);
  endtask

  task automatic t_disabled_tick();
    int s0;
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'hFFFF);
    s0 = sec_cnt;
    run(32768);
    idle();
    stat_bit(4, 1'b1, "R7 status sets while disabled");
    check(sec_cnt == s0, "R7 no tick while disabled", sec_cnt - s0, 0);
  endtask

  task automatic t_reserved();
    logic [15:0] v;
    int s0;
    wr(2'd0, 16'h00E0);
    wr(2'd1, 16'hFFFF);
    s0 = sec_cnt;
    run(2000);
    idle();
    rd(2'd1, v);
    check(v == 16'h0, "R8 reserved select stops events", int'(v), 0);
    check(sec_cnt == s0, "R8 no tick", sec_cnt - s0, 0);
    rd(2'd0, v);
    check(v == 16'h00E0, "R1 control read back", int'(v), 16'h00E0);
  endtask

  task automatic t_restart();
    // 40 ticks, restart, 63 more: no 512Hz event at 103 total
    wr(2'd0, 16'h0080);
    wr(2'd1, 16'hFFFF);
    run(40);
    wr(2'd0, 16'h0080);
    repeat (5) idle();
    run(63);  stat_bit(15, 1'b0, "R9 restart resets divider");
    run(1);   stat_bit(15, 1'b1, "R9 count from restart");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    idle();
    t_reset();
    t_ref_a();
    t_ref_b();
    t_ref_c();
    t_w1c_and_irq();
    t_disabled_tick();
    t_reserved();
    t_restart();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule